// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a processor reach the configuration registers of a PHY through a small window of 32-bit registers. A command word selects the PHY port, the register inside it and the operation. A read command starts a transaction on the PHY-side register port as soon as it is written. A write command only arms the bridge. The write itself starts when software stores the data word with its top bit set.

Software learns that a transaction has finished from bit 31 of the data registers, and the two registers use that bit in opposite senses. In the read-data register, bit 31 becomes 1 when the PHY returns data. In the write-data register, bit 31 is 1 while a write is pending, and hardware clears it once the PHY has accepted the write. A status register shows the busy state. Software is expected to poll a small number of times, so the bridge adds no wait states of its own: a request is raised in the cycle after the launching register write, and the result is captured in the cycle after the PHY acknowledges.

The CPU side is a single-cycle register port. A write happens when `csr_sel` and `csr_we` are both high at a clock edge. Reads are combinational on `csr_addr`. Register selects are 0 for the command word, 1 for write data, 2 for read data and 3 for status, with busy in bit 0 of the status register. Writes to selects 2 and 3 have no effect.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, all four registers read 0 and `phy_req` is low.
- R2: A command word written while the bridge is idle reads back unchanged from select 0, whatever its code.
- R3: A command with code 1 in bits 31:20 starts a read. In the next cycle, `phy_req` is 1, `phy_we` is 0, `phy_port` equals bits 19:16 and `phy_reg` equals bits 15:0. In the same cycle, bit 31 of the read-data register is cleared and its low bits are kept.
- R4: In the cycle after `phy_ack` is high during a read, the read-data register holds bit 31 = 1 with `phy_rdata` zero-extended below it, and `phy_req` is low.
- R5: A command with code 0 arms a write without starting it. A later write-data store with bit 31 set launches the write, with `phy_we` = 1 and `phy_wdata` equal to the low DATA_W bits of the stored word. Bit 31 of the write-data register reads 1 until the cycle after `phy_ack`, when it reads 0.
- R6: A write-data store with bit 31 clear, or with bit 31 set but no armed write, keeps the low bits, reads back with bit 31 = 0 and starts nothing. A launched write consumes the arming.
- R7: A command code other than 0 or 1 starts no transaction and cancels any armed write.
- R8: From the cycle after a launch until the cycle after its acknowledge, status bit 0 reads 1. Writes to the command and write-data registers in that interval, including one in the acknowledge cycle itself, change neither register and start nothing.
- R9: While `phy_req` is high and `phy_ack` is low, `phy_req`, `phy_we`, `phy_port`, `phy_reg` and `phy_wdata` hold their values into the next cycle.
- R10: Only one transaction is outstanding at a time: after an acknowledged cycle, `phy_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_sel | input | 1 | CPU access strobe |
| csr_we | input | 1 | CPU write enable (with csr_sel) |
| csr_addr | input | 2 | Register select: 0 command, 1 write data, 2 read data, 3 status |
| csr_wdata | input | 32 | CPU write data |
| csr_rdata | output | 32 | CPU read data, combinational on csr_addr |
| phy_req | output | 1 | PHY request, held until acknowledged |
| phy_we | output | 1 | 1 for a write, 0 for a read |
| phy_port | output | 4 | PHY port number |
| phy_reg | output | 16 | PHY register address |
| phy_wdata | output | DATA_W | PHY write data |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | DATA_W | PHY read data, valid with phy_ack |

## Verification
Two events can land on the same clock edge: a PHY acknowledge that ends a transaction, and a CPU write to the command register. The bench makes them coincide by driving `phy_ack` and a new read command within one cycle while a read is pending. It then checks three things: the command register still holds the old word, the read-data register carries the acknowledged value with its flag set, and no second request follows. The same behavioural model also covers a zero-delay acknowledge, where completion arrives in the first request cycle.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
    localparam int WORD_W   = 32;
    localparam int REG_LSB  = 0;
    localparam int REG_W    = 16;
    localparam int PORT_LSB = 16;
    localparam int PORT_W   = 4;
    localparam int CODE_LSB = 20;
    localparam int CODE_W   = 12;
    localparam int FLAG_BIT = 31;

    localparam logic [CODE_W-1:0] CODE_WRITE = 12'd0;
    localparam logic [CODE_W-1:0] CODE_READ  = 12'd1;

    localparam logic [1:0] SEL_CMD   = 2'd0;
    localparam logic [1:0] SEL_WDATA = 2'd1;
    localparam logic [1:0] SEL_RDATA = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_WRITE} sq_e;

    function automatic op_e decode_op(input logic [CODE_W-1:0] code);
        if (code == CODE_READ)       return OP_READ;
        else if (code == CODE_WRITE) return OP_WRITE;
        else                         return OP_NONE;
    endfunction
endpackage

// File: rtl/phyb_seq.sv
module phyb_seq
    import phyb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd_i,
    input  logic start_wr_i,
    input  logic ack_i,
    output logic req_o,
    output logic we_o,
    output logic busy_o,
    output logic rd_done_o,
    output logic wr_done_o
);
    typedef struct packed {
        sq_e st;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        rd_done_o = 1'b0;
        wr_done_o = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start_rd_i)      seq_d.st = SQ_READ;
                else if (start_wr_i) seq_d.st = SQ_WRITE;
            end
            SQ_READ: begin
                if (ack_i) begin
                    rd_done_o = 1'b1;
                    seq_d.st  = SQ_IDLE;
                end
            end
            SQ_WRITE: begin
                if (ack_i) begin
                    wr_done_o = 1'b1;
                    seq_d.st  = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SQ_IDLE};
        else        seq_q <= seq_d;
    end

    assign req_o  = (seq_q.st != SQ_IDLE);
    assign we_o   = (seq_q.st == SQ_WRITE);
    assign busy_o = req_o;
endmodule

// File: rtl/phyb_rd_mux.sv
module phyb_rd_mux
    import phyb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        sel_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              wflag_i,
    input  logic [DATA_W-1:0] wdat_i,
    input  logic [WORD_W-1:0] rdat_i,
    input  logic              busy_i,
    output logic [WORD_W-1:0] dout_o
);
    localparam int LOW_W = WORD_W - 1;

    always_comb begin
        case (sel_i)
            SEL_CMD:   dout_o = cmd_i;
            SEL_WDATA: dout_o = {wflag_i, LOW_W'(wdat_i)};
            SEL_RDATA: dout_o = rdat_i;
            SEL_STAT:  dout_o = {{LOW_W{1'b0}}, busy_i};
            default:   dout_o = '0;
        endcase
    end
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
    import phyb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_sel,
    input  logic              csr_we,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [3:0]        phy_port,
    output logic [15:0]       phy_reg,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata
);
    localparam int LOW_W = WORD_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [DATA_W-1:0] wdat;
        logic              wflag;
        logic [WORD_W-1:0] rdat;
        logic              armed;
    } regs_s;

    regs_s regs_d, regs_q;

    logic busy_w, rd_done_w, wr_done_w;
    logic wr_access, start_rd, start_wr;
    op_e  cmd_op;

    // Register writes are accepted only while no transaction is pending
    always_comb begin
        wr_access = csr_sel && csr_we && !busy_w;
        cmd_op    = decode_op(csr_wdata[CODE_LSB +: CODE_W]);
        start_rd  = wr_access && (csr_addr == SEL_CMD) && (cmd_op == OP_READ);
        start_wr  = wr_access && (csr_addr == SEL_WDATA) && csr_wdata[FLAG_BIT] && regs_q.armed;
    end

    always_comb begin
        regs_d = regs_q;
        if (rd_done_w) regs_d.rdat  = {1'b1, LOW_W'(phy_rdata)};
        if (wr_done_w) regs_d.wflag = 1'b0;
        if (wr_access) begin
            case (csr_addr)
                SEL_CMD: begin
                    regs_d.cmd   = csr_wdata;
                    regs_d.armed = (cmd_op == OP_WRITE);
                    if (cmd_op == OP_READ) regs_d.rdat[FLAG_BIT] = 1'b0;
                end
                SEL_WDATA: begin
                    regs_d.wdat  = csr_wdata[DATA_W-1:0];
                    regs_d.wflag = start_wr;
                    if (start_wr) regs_d.armed = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    phyb_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rd_i (start_rd),
        .start_wr_i (start_wr),
        .ack_i      (phy_ack),
        .req_o      (phy_req),
        .we_o       (phy_we),
        .busy_o     (busy_w),
        .rd_done_o  (rd_done_w),
        .wr_done_o  (wr_done_w)
    );

    phyb_rd_mux #(.DATA_W(DATA_W)) u_rd_mux (
        .sel_i   (csr_addr),
        .cmd_i   (regs_q.cmd),
        .wflag_i (regs_q.wflag),
        .wdat_i  (regs_q.wdat),
        .rdat_i  (regs_q.rdat),
        .busy_i  (busy_w),
        .dout_o  (csr_rdata)
    );

    assign phy_port  = regs_q.cmd[PORT_LSB +: PORT_W];
    assign phy_reg   = regs_q.cmd[REG_LSB +: REG_W];
    assign phy_wdata = regs_q.wdat;

    // State views for the bound checker
    logic [WORD_W-1:0] cmd_word_w;
    logic              rd_flag_w;
    logic              wr_flag_w;
    assign cmd_word_w = regs_q.cmd;
    assign rd_flag_w  = regs_q.rdat[FLAG_BIT];
    assign wr_flag_w  = regs_q.wflag;
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_sel,
    input logic              csr_we,
    input logic [1:0]        csr_addr,
    input logic [31:0]       csr_wdata,
    input logic              phy_req,
    input logic              phy_we,
    input logic [3:0]        phy_port,
    input logic [15:0]       phy_reg,
    input logic [DATA_W-1:0] phy_wdata,
    input logic              phy_ack,
    input logic [31:0]       cmd_word,
    input logic              rd_flag,
    input logic              wr_flag
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_we) && $stable(phy_port)
                                   && $stable(phy_reg) && $stable(phy_wdata)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req);

    assert_rdclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_req) && !phy_we) |-> !rd_flag);

    assert_rddone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_we && phy_ack) |=> rd_flag);

    assert_wpend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we) |-> wr_flag);

    assert_wdone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we && phy_ack) |=> !wr_flag);

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && csr_sel && csr_we && csr_addr == 2'd0) |=> $stable(cmd_word));

    assert_nolaunch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_req && csr_sel && csr_we && csr_addr == 2'd0 && csr_wdata[31:20] > 12'd1)
        |=> !phy_req);
endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_sel   (csr_sel),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_port  (phy_port),
    .phy_reg   (phy_reg),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .cmd_word  (cmd_word_w),
    .rd_flag   (rd_flag_w),
    .wr_flag   (wr_flag_w)
);

// File: tb/phy_reg_bridge_tb.sv
`timescale 1ns/1ps
module phy_reg_bridge_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_sel = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = 2'd0;
    logic [31:0]   csr_wdata = 32'd0;
    logic [31:0]   csr_rdata;
    logic          phy_req, phy_we;
    logic [3:0]    phy_port;
    logic [15:0]   phy_reg;
    logic [DW-1:0] phy_wdata;
    logic          phy_ack = 1'b0;
    logic [DW-1:0] phy_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    phy_reg_bridge #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_port(phy_port), .phy_reg(phy_reg),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // Behavioural reference model
    logic [31:0]   m_cmd, m_rd;
    logic [DW-1:0] m_wd;
    logic          m_wflag, m_armed, m_busy, m_we;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmd <= 0; m_rd <= 0; m_wd <= 0;
            m_wflag <= 0; m_armed <= 0; m_busy <= 0; m_we <= 0;
        end else begin
            if (m_busy && phy_ack) begin
                m_busy <= 0;
                if (m_we) m_wflag <= 0;
                else      m_rd <= {1'b1, 15'd0, phy_rdata};
            end
            if (!m_busy && csr_sel && csr_we) begin
                if (csr_addr == 2'd0) begin
                    m_cmd <= csr_wdata;
                    if (csr_wdata[31:20] == 12'd1) begin
                        m_busy <= 1; m_we <= 0; m_armed <= 0;
                        m_rd <= {1'b0, m_rd[30:0]};
                    end else begin
                        m_armed <= (csr_wdata[31:20] == 12'd0);
                    end
                end else if (csr_addr == 2'd1) begin
                    m_wd <= csr_wdata[DW-1:0];
                    if (csr_wdata[31] && m_armed) begin
                        m_wflag <= 1; m_busy <= 1; m_we <= 1; m_armed <= 0;
                    end else begin
                        m_wflag <= 0;
                    end
                end
            end
        end
    end

    function automatic logic [31:0] model_reg(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmd;
            2'd1:    return {m_wflag, 15'd0, m_wd};
            2'd2:    return m_rd;
            default: return {31'd0, m_busy};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the PHY side against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R8 R10 phy_req", {31'd0, phy_req}, {31'd0, m_busy});
            if (m_busy) begin
                chk("R3 R5 phy_we", {31'd0, phy_we}, {31'd0, m_we});
                chk("R9 phy_port", {28'd0, phy_port}, {28'd0, m_cmd[19:16]});
                chk("R9 phy_reg", {16'd0, phy_reg}, m_cmd[15:0]);
                if (m_we) chk("R9 phy_wdata", {16'd0, phy_wdata}, {16'd0, m_wd});
            end
        end
    end

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_sel = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_sel = 0; csr_we = 0;
    endtask

    task automatic cpu_read(input logic [1:0] a, input string tag);
        @(negedge clk);
        csr_addr = a;
        #2;
        chk(tag, csr_rdata, model_reg(a));
    endtask

    task automatic cpu_read_exp(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_addr = a;
        #2;
        chk(tag, csr_rdata, exp);
        chk({tag, " model"}, csr_rdata, model_reg(a));
    endtask

    // Acknowledge at the current negedge (call right after a negedge)
    task automatic ack_now(input logic [DW-1:0] v);
        phy_ack = 1; phy_rdata = v;
        @(negedge clk);
        phy_ack = 0;
    endtask

    task automatic ack_later(input logic [DW-1:0] v);
        @(negedge clk);
        ack_now(v);
    endtask

    task automatic finish_up;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        cpu_read_exp(2'd0, 32'h0, "R1 cmd");
        cpu_read_exp(2'd1, 32'h0, "R1 wdata");
        cpu_read_exp(2'd2, 32'h0, "R1 rdata");
        cpu_read_exp(2'd3, 32'h0, "R1 stat");

        // R2 R3 R4: read with delayed acknowledge
        cpu_write(2'd0, 32'h0013_1234);
        cpu_read_exp(2'd0, 32'h0013_1234, "R2 readback");
        cpu_read_exp(2'd3, 32'h1, "R8 busy");
        cpu_read_exp(2'd2, 32'h0, "R3 flag clear");
        ack_later(16'h5A5A);
        cpu_read_exp(2'd2, 32'h8000_5A5A, "R4 read data");
        cpu_read_exp(2'd3, 32'h0, "R8 idle");

        // R3: a new read clears the flag and keeps the low bits
        cpu_write(2'd0, 32'h001A_0042);
        cpu_read_exp(2'd2, 32'h0000_5A5A, "R3 flag cleared");
        ack_later(16'h00C3);
        cpu_read_exp(2'd2, 32'h8000_00C3, "R4 second read");

        // R4: zero-delay acknowledge
        cpu_write(2'd0, 32'h001F_FFFF);
        ack_now(16'hFFFF);
        cpu_read_exp(2'd2, 32'h8000_FFFF, "R4 zero delay");

        // R5: write sequence
        cpu_write(2'd0, 32'h0005_00AB);
        cpu_read_exp(2'd3, 32'h0, "R5 cmd alone");
        cpu_write(2'd1, 32'h8000_BEEF);
        cpu_read_exp(2'd1, 32'h8000_BEEF, "R5 pending flag");
        ack_later(16'h0);
        cpu_read_exp(2'd1, 32'h0000_BEEF, "R5 flag cleared");

        // R6: flag without arming, flag absent, arming consumed
        cpu_write(2'd1, 32'h8000_1111);
        cpu_read_exp(2'd1, 32'h0000_1111, "R6 unarmed");
        cpu_read_exp(2'd3, 32'h0, "R6 unarmed idle");
        cpu_write(2'd0, 32'h0002_0007);
        cpu_write(2'd1, 32'h0000_2222);
        cpu_read_exp(2'd3, 32'h0, "R6 no flag");
        cpu_read_exp(2'd1, 32'h0000_2222, "R6 no flag data");

        // R7: unknown code starts nothing and cancels arming
        cpu_write(2'd0, 32'h0073_0001);
        cpu_read_exp(2'd0, 32'h0073_0001, "R7 readback");
        cpu_read_exp(2'd3, 32'h0, "R7 idle");
        cpu_write(2'd1, 32'h8000_3333);
        cpu_read_exp(2'd3, 32'h0, "R7 disarmed");
        cpu_read_exp(2'd2, 32'h8000_FFFF, "R7 rdata kept");

        // R8: writes while busy are ignored
        cpu_write(2'd0, 32'h0014_0010);
        cpu_write(2'd0, 32'h0016_0099);
        cpu_read_exp(2'd0, 32'h0014_0010, "R8 cmd ignored");
        cpu_write(2'd1, 32'h8000_7777);
        cpu_read(2'd1, "R8 wdata ignored");
        cpu_read_exp(2'd1, 32'h0000_3333, "R8 wdata value");

        // R8 R4: acknowledge and command write on the same edge
        @(negedge clk);
        phy_ack = 1; phy_rdata = 16'h0F0F;
        csr_sel = 1; csr_we = 1; csr_addr = 2'd0; csr_wdata = 32'h0017_0055;
        @(negedge clk);
        phy_ack = 0; csr_sel = 0; csr_we = 0;
        cpu_read_exp(2'd0, 32'h0014_0010, "R8 collision cmd");
        cpu_read_exp(2'd2, 32'h8000_0F0F, "R4 collision data");
        cpu_read_exp(2'd3, 32'h0, "R10 collision idle");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule